// File: doc/BRIEF.md
# Dictionary-Indexed Instruction Line Expander

This block refills one instruction-cache line from a compressed program image. In that image every 32-bit instruction is stored as a 16-bit index. The index selects an entry in a table that holds each distinct instruction once, so instructions that repeat share a single entry. When a miss request arrives, the block walks the line's words in ascending order. For each word it reads the index from a compressed-text memory port, uses that index to read the table through a dictionary port, and writes the restored 32-bit word into a cache fill port. Each write carries the line address, the word offset and a one-hot word strobe, so the cache can mark each written word valid.

Two fill modes are offered. A full fill restores all eight words of a 32-byte line. A partial fill starts at the word that missed and runs to the end of the line; the words in front of it are left unwritten. Both memory ports have one cycle of read latency, and the block keeps one word moving through each stage per cycle. The index for native instruction n (its byte address divided by four) sits at byte address `ct_base + 2*n` of the compressed text. A miss that arrives while a refill is running is dropped. A one-cycle completion pulse follows the last write.

Top module: `icache_line_expander`

## Requirements
- R1: After reset, `busy`, `ct_rd_en`, `dict_rd_en`, `fill_we`, `fill_wstrb` and `done` are all low.
- R2: A miss is taken at a clock edge where `miss_valid` is high and `busy` is low. In the cycle after that edge, `ct_rd_en` is high with `ct_rd_addr = ct_base + 2*((line_addr>>2) + s)`, where s is the starting word. Each following cycle issues the next word at an address 2 higher, ending with word 7.
- R3: One cycle after each compressed-text read, `dict_rd_en` is high and `dict_rd_addr` equals the 16-bit index the compressed-text port returned.
- R4: The first fill write appears 3 cycles after the accepting edge. `fill_data` equals the dictionary word returned for that word's index, and `fill_line_addr` equals `miss_addr` with its low 5 bits cleared. The low 2 bits of `miss_addr` have no effect.
- R5: When `miss_partial` is 0 (full mode), eight writes with offsets 0,1,...,7 appear on consecutive cycles.
- R6: When `miss_partial` is 1 (partial mode), the writes start at offset `miss_addr[4:2]` and run one per cycle up to offset 7. Lower offsets are never written.
- R7: `fill_wstrb` is one-hot with bit `fill_off` set while `fill_we` is high, and zero otherwise.
- R8: `done` is high for exactly one cycle, the cycle after the last write. `busy` is low in that cycle and high from the accepting edge up to that cycle.
- R9: A miss request made while `busy` is high is ignored. The running refill is unchanged, and no new compressed-text read follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ct_base | input | 32 | Byte base of the compressed text |
| miss_valid | input | 1 | Miss request |
| miss_addr | input | 32 | Byte address of the instruction that missed |
| miss_partial | input | 1 | 1 = partial fill from the missed word, 0 = full line |
| busy | output | 1 | Refill in progress; requests are dropped |
| ct_rd_en | output | 1 | Compressed-text read strobe |
| ct_rd_addr | output | 32 | Compressed-text byte address |
| ct_rd_data | input | 16 | Index returned one cycle after the read |
| dict_rd_en | output | 1 | Dictionary read strobe |
| dict_rd_addr | output | 16 | Dictionary entry number |
| dict_rd_data | input | 32 | Instruction returned one cycle after the read |
| fill_we | output | 1 | Cache fill write enable |
| fill_line_addr | output | 32 | Line-aligned byte address of the line being filled |
| fill_off | output | 3 | Word offset inside the line |
| fill_data | output | 32 | Restored instruction |
| fill_wstrb | output | 8 | One-hot per-word write strobe |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest situation to reach from the ports is a second miss that arrives in the middle of a refill, while words are still spread across the read, lookup and fill stages. The bench pulses `miss_valid` with an unrelated address two cycles into randomly chosen refills. It then checks every stage output cycle by cycle against the first request, and afterwards confirms that no read follows. Partial starts at offsets 0 and 7 and misaligned miss addresses are driven as directed cases. They are mixed with random addresses, random bases and random modes. The compressed text is modelled with only 32 distinct indices, so dictionary entries are shared across words.

// File: rtl/lxp_pkg.sv
package lxp_pkg;

   typedef enum logic {
      FILL_WHOLE = 1'b0,
      FILL_TAIL  = 1'b1
   } fill_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lxp_issue.sv
module lxp_issue #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned OFF_W      = 3,
   parameter int unsigned BYTE_SH    = 2,
   parameter int unsigned CT_SH      = 1,
   parameter bit          PARTIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              miss_partial,
   input  logic [ADDR_W-1:0] ct_base,
   output logic              iss_v,
   output logic [OFF_W-1:0]  iss_off,
   output logic              iss_last,
   output logic [ADDR_W-1:0] ct_rd_addr,
   output logic [ADDR_W-1:0] line_addr
);
   import lxp_pkg::*;

   localparam int unsigned         LINE_SH  = OFF_W + BYTE_SH;
   localparam logic [ADDR_W-1:0]   LOW_MASK = ADDR_W'((64'd1 << LINE_SH) - 64'd1);
   localparam logic [ADDR_W-1:0]   CT_STEP  = ADDR_W'(64'd1 << CT_SH);
   localparam logic [OFF_W-1:0]    OFF_LAST = '1;

   logic              active_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] line_q;
   logic [OFF_W-1:0]  start_off;
   logic [ADDR_W-1:0] new_line;
   logic [ADDR_W-1:0] new_ptr;

   // The fill mode picks the starting word; the tail variant exists only when enabled.
   generate
      if (PARTIAL_EN) begin : g_tail
         fill_mode_e mode;
         assign mode      = fill_mode_e'(miss_partial);
         assign start_off = (mode == FILL_TAIL) ? OFF_W'(miss_addr >> BYTE_SH) : '0;
      end else begin : g_whole
         assign start_off = '0;
      end
   endgenerate

   assign new_line = miss_addr & ~LOW_MASK;
   assign new_ptr  = ct_base + ((new_line >> BYTE_SH) << CT_SH)
                   + (ADDR_W'(start_off) << CT_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         off_q    <= '0;
         ptr_q    <= '0;
         line_q   <= '0;
      end else if (accept) begin
         active_q <= 1'b1;
         off_q    <= start_off;
         ptr_q    <= new_ptr;
         line_q   <= new_line;
      end else if (active_q) begin
         if (off_q == OFF_LAST) begin
            active_q <= 1'b0;
         end else begin
            off_q <= off_q + 1'b1;
            ptr_q <= ptr_q + CT_STEP;
         end
      end
   end

   assign iss_v      = active_q;
   assign iss_off    = off_q;
   assign iss_last   = active_q && (off_q == OFF_LAST);
   assign ct_rd_addr = ptr_q;
   assign line_addr  = line_q;

   // R2: consecutive reads step by one index width
   a_r2_ct_step : assert property (@(posedge clk) disable iff (!rst_n)
      (iss_v && !iss_last && !accept) |=> (iss_v && ct_rd_addr == $past(ct_rd_addr) + CT_STEP));

endmodule

// File: rtl/lxp_lookup.sv
module lxp_lookup #(
   parameter int unsigned OFF_W = 3,
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_v,
   input  logic [OFF_W-1:0] iss_off,
   input  logic             iss_last,
   input  logic [IDX_W-1:0] ct_rd_data,
   output logic             dict_rd_en,
   output logic [IDX_W-1:0] dict_rd_addr,
   output logic             s2_v,
   output logic [OFF_W-1:0] s2_off,
   output logic             s2_last,
   output logic             lookup_busy
);
   logic             s1_v;
   logic [OFF_W-1:0] s1_off;
   logic             s1_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_off  <= '0;
         s1_last <= 1'b0;
         s2_v    <= 1'b0;
         s2_off  <= '0;
         s2_last <= 1'b0;
      end else begin
         s1_v    <= iss_v;
         s1_off  <= iss_off;
         s1_last <= iss_last;
         s2_v    <= s1_v;
         s2_off  <= s1_off;
         s2_last <= s1_last;
      end
   end

   // Index from the compressed text arrives now and goes straight to the dictionary.
   assign dict_rd_en   = s1_v;
   assign dict_rd_addr = ct_rd_data;
   assign lookup_busy  = s1_v | s2_v;

   // R3: each dictionary read follows exactly one compressed-text read
   a_r3_lookup_follows : assert property (@(posedge clk) disable iff (!rst_n)
      iss_v |=> dict_rd_en);

endmodule

// File: rtl/lxp_fill.sv
module lxp_fill #(
   parameter int unsigned INSN_W     = 32,
   parameter int unsigned LINE_WORDS = 8,
   parameter int unsigned OFF_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s2_v,
   input  logic [OFF_W-1:0]      s2_off,
   input  logic                  s2_last,
   input  logic [INSN_W-1:0]     dict_rd_data,
   output logic                  fill_we,
   output logic [OFF_W-1:0]      fill_off,
   output logic [INSN_W-1:0]     fill_data,
   output logic [LINE_WORDS-1:0] fill_wstrb,
   output logic                  done
);
   logic                  last_q;
   logic [LINE_WORDS-1:0] dec;

   generate
      for (genvar gi = 0; gi < LINE_WORDS; gi++) begin : g_dec
         assign dec[gi] = (s2_off == OFF_W'(gi));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_we    <= 1'b0;
         fill_off   <= '0;
         fill_data  <= '0;
         fill_wstrb <= '0;
         last_q     <= 1'b0;
         done       <= 1'b0;
      end else begin
         fill_we    <= s2_v;
         last_q     <= s2_v & s2_last;
         done       <= fill_we & last_q;
         fill_wstrb <= s2_v ? dec : '0;
         if (s2_v) begin
            fill_off  <= s2_off;
            fill_data <= dict_rd_data;
         end
      end
   end

   // R5/R6: writes climb one offset per cycle until the line end
   a_r5_ascending : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && !last_q) |=> (fill_we && fill_off == OFF_W'($past(fill_off) + 1'b1)));

   // R7: strobe is one-hot at the written offset
   a_r7_strobe_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |-> ($countones(fill_wstrb) == 1 && fill_wstrb[fill_off]));

   a_r7_strobe_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !fill_we |-> (fill_wstrb == '0));

   // R8: completion follows the last write and lasts one cycle
   a_r8_done_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fill_we && last_q));

   a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/icache_line_expander.sv
module icache_line_expander #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IDX_W      = 16,
   parameter int unsigned INSN_W     = 32,
   parameter int unsigned LINE_WORDS = 8,
   parameter bit          PARTIAL_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     ct_base,
   input  logic                  miss_valid,
   input  logic [ADDR_W-1:0]     miss_addr,
   input  logic                  miss_partial,
   output logic                  busy,
   output logic                  ct_rd_en,
   output logic [ADDR_W-1:0]     ct_rd_addr,
   input  logic [IDX_W-1:0]      ct_rd_data,
   output logic                  dict_rd_en,
   output logic [IDX_W-1:0]      dict_rd_addr,
   input  logic [INSN_W-1:0]     dict_rd_data,
   output logic                  fill_we,
   output logic [ADDR_W-1:0]     fill_line_addr,
   output logic [$clog2(LINE_WORDS)-1:0] fill_off,
   output logic [INSN_W-1:0]     fill_data,
   output logic [LINE_WORDS-1:0] fill_wstrb,
   output logic                  done
);
   import lxp_pkg::*;

   localparam int unsigned OFF_W   = $clog2(LINE_WORDS);
   localparam int unsigned BYTE_SH = $clog2(INSN_W / 8);
   localparam int unsigned CT_SH   = $clog2(IDX_W / 8);

   generate
      if (!is_pow2(LINE_WORDS) || LINE_WORDS < 2) begin : g_bad_words
         $error("LINE_WORDS must be a power of two of at least 2");
      end
      if ((INSN_W % 8) != 0 || !is_pow2(INSN_W / 8)) begin : g_bad_insn
         $error("INSN_W must be a power-of-two number of bytes");
      end
      if ((IDX_W % 8) != 0 || !is_pow2(IDX_W / 8)) begin : g_bad_idx
         $error("IDX_W must be a power-of-two number of bytes");
      end
      if (ADDR_W <= OFF_W + BYTE_SH) begin : g_bad_addr
         $error("ADDR_W too narrow for the line size");
      end
   endgenerate

   logic             accept;
   logic             iss_v;
   logic [OFF_W-1:0] iss_off;
   logic             iss_last;
   logic             s2_v;
   logic [OFF_W-1:0] s2_off;
   logic             s2_last;
   logic             lookup_busy;

   assign busy   = iss_v | lookup_busy | fill_we;
   assign accept = miss_valid & ~busy;

   lxp_issue #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTE_SH(BYTE_SH),
      .CT_SH(CT_SH), .PARTIAL_EN(PARTIAL_EN)
   ) u_issue (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .miss_addr(miss_addr), .miss_partial(miss_partial), .ct_base(ct_base),
      .iss_v(iss_v), .iss_off(iss_off), .iss_last(iss_last),
      .ct_rd_addr(ct_rd_addr), .line_addr(fill_line_addr)
   );

   assign ct_rd_en = iss_v;

   lxp_lookup #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_lookup (
      .clk(clk), .rst_n(rst_n),
      .iss_v(iss_v), .iss_off(iss_off), .iss_last(iss_last),
      .ct_rd_data(ct_rd_data),
      .dict_rd_en(dict_rd_en), .dict_rd_addr(dict_rd_addr),
      .s2_v(s2_v), .s2_off(s2_off), .s2_last(s2_last),
      .lookup_busy(lookup_busy)
   );

   lxp_fill #(.INSN_W(INSN_W), .LINE_WORDS(LINE_WORDS), .OFF_W(OFF_W)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .s2_v(s2_v), .s2_off(s2_off), .s2_last(s2_last),
      .dict_rd_data(dict_rd_data),
      .fill_we(fill_we), .fill_off(fill_off), .fill_data(fill_data),
      .fill_wstrb(fill_wstrb), .done(done)
   );

   // R9: a request while busy leaves the captured line untouched
   a_r9_ignore_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && miss_valid) |=> $stable(fill_line_addr));

   // R8: a refill runs to completion before the block frees up
   a_r8_busy_until_done : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fill_we && !lookup_busy && iss_v) |=> busy);

endmodule

// File: tb/icache_line_expander_bench.sv
module icache_line_expander_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ct_base = '0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_addr = '0;
   logic        miss_partial = 1'b0;
   logic        busy, ct_rd_en, dict_rd_en, fill_we, done;
   logic [31:0] ct_rd_addr, fill_line_addr, fill_data;
   logic [15:0] ct_rd_data = '0, dict_rd_addr;
   logic [31:0] dict_rd_data = '0;
   logic [2:0]  fill_off;
   logic [7:0]  fill_wstrb;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   icache_line_expander u_icache_line_expander (
      .clk(clk), .rst_n(rst_n), .ct_base(ct_base),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_partial(miss_partial),
      .busy(busy), .ct_rd_en(ct_rd_en), .ct_rd_addr(ct_rd_addr), .ct_rd_data(ct_rd_data),
      .dict_rd_en(dict_rd_en), .dict_rd_addr(dict_rd_addr), .dict_rd_data(dict_rd_data),
      .fill_we(fill_we), .fill_line_addr(fill_line_addr), .fill_off(fill_off),
      .fill_data(fill_data), .fill_wstrb(fill_wstrb), .done(done)
   );

   // Compressed text holds few distinct indices so entries are shared.
   function automatic logic [15:0] ct_fn(input logic [31:0] a);
      logic [31:0] h;
      h = (a * 32'h9E37) ^ (a >> 5);
      return {11'h0, h[4:0]};
   endfunction

   function automatic logic [31:0] dict_fn(input logic [15:0] i);
      return {i ^ 16'h3C5A, ~i};
   endfunction

   function automatic logic [31:0] ct_exp(input logic [31:0] base, input logic [31:0] line,
                                          input int k);
      return base + ((line >> 2) << 1) + 32'(2 * k);
   endfunction

   always @(posedge clk) begin
      if (ct_rd_en)   ct_rd_data   <= ct_fn(ct_rd_addr);
      if (dict_rd_en) dict_rd_data <= dict_fn(dict_rd_addr);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_miss(input logic [31:0] a, input logic p, input logic [31:0] base,
                          input logic inj);
      int start;
      int n;
      logic [31:0] line;
      start = p ? int'(a[4:2]) : 0;
      n     = 8 - start;
      line  = a & ~32'h1F;
      @(negedge clk);
      ct_base = base; miss_valid = 1'b1; miss_addr = a; miss_partial = p;
      @(negedge clk);
      miss_valid = 1'b0;
      for (int c = 0; c <= n + 3; c++) begin
         // R2: compressed-text reads
         if (c < n) begin
            chk("R2 ct_rd_en", 64'(ct_rd_en), 64'(1));
            chk("R2 ct_rd_addr", 64'(ct_rd_addr), 64'(ct_exp(base, line, start + c)));
         end else begin
            chk("R2 ct_rd_en idle", 64'(ct_rd_en), 64'(0));
         end
         // R3: dictionary reads
         if (c >= 1 && c <= n) begin
            chk("R3 dict_rd_en", 64'(dict_rd_en), 64'(1));
            chk("R3 dict_rd_addr", 64'(dict_rd_addr),
                64'(ct_fn(ct_exp(base, line, start + c - 1))));
         end
         // R4..R7: fill writes
         if (c >= 3 && c < 3 + n) begin
            chk("R4 fill_we", 64'(fill_we), 64'(1));
            chk("R4 fill_data", 64'(fill_data),
                64'(dict_fn(ct_fn(ct_exp(base, line, start + c - 3)))));
            chk("R4 fill_line_addr", 64'(fill_line_addr), 64'(line));
            chk(p ? "R6 fill_off" : "R5 fill_off", 64'(fill_off), 64'(start + c - 3));
            chk("R7 fill_wstrb", 64'(fill_wstrb), 64'(8'(1) << (start + c - 3)));
         end else begin
            chk(p ? "R6 no write" : "R5 no write", 64'(fill_we), 64'(0));
            chk("R7 strobe idle", 64'(fill_wstrb), 64'(0));
         end
         // R8: busy and completion
         chk("R8 done", 64'(done), 64'(c == n + 3));
         chk("R8 busy", 64'(busy), 64'(c != n + 3));
         // R9: stray request while busy
         if (inj && c == 1) begin
            miss_valid = 1'b1; miss_addr = a ^ 32'h0ABC_0040; miss_partial = ~p;
         end
         if (inj && c == 2) miss_valid = 1'b0;
         @(negedge clk);
      end
      chk("R9 no extra read", 64'(ct_rd_en), 64'(0));
      chk("R9 stays idle", 64'(busy), 64'(0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", 64'(busy), 64'(0));
      chk("R1 ct_rd_en", 64'(ct_rd_en), 64'(0));
      chk("R1 dict_rd_en", 64'(dict_rd_en), 64'(0));
      chk("R1 fill_we", 64'(fill_we), 64'(0));
      chk("R1 fill_wstrb", 64'(fill_wstrb), 64'(0));
      chk("R1 done", 64'(done), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", 64'(busy), 64'(0));

      do_miss(32'h0000_0000, 1'b0, 32'h0010_0000, 1'b0);  // R5 full line at zero
      do_miss(32'h0000_1234, 1'b0, 32'h0020_0000, 1'b0);  // R4 misaligned, full mode
      do_miss(32'h0000_401C, 1'b1, 32'h0030_0000, 1'b0);  // R6 single last word
      do_miss(32'h0000_5000, 1'b1, 32'h0000_8000, 1'b0);  // R6 start at word 0
      do_miss(32'h0000_6013, 1'b1, 32'h0000_0000, 1'b1);  // R9 stray request, R4 low bits
      do_miss(32'hFFFF_FFE8, 1'b1, 32'hFFFF_F000, 1'b1);  // R2 address wrap

      for (int i = 0; i < 60; i++) begin
         do_miss($urandom, 1'($urandom), $urandom, 1'($urandom));
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule